// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps speculatively executed instructions in the order they were dispatched and retires them strictly oldest first. When dispatch hands it an instruction, it takes a free slot at the tail and returns that slot's index. The index serves as the rename tag under which the instruction's result will later appear on the result broadcast bus. The block also keeps a rename map from architectural register to the youngest in-flight writer. Dispatch logic queries this map for its source registers and gets back whether a source is still pending, which tag will produce it, and the finished value if the producer has already completed.

The oldest slot leaves the buffer as soon as its result has arrived. Depending on the kind of instruction, it presents a register write, a store, or a branch retirement. If the retiring branch was mispredicted, every younger slot is dropped and the rename map is wiped in the same cycle. If the oldest slot carries a fault, it does not retire: the block raises a trap with the faulting PC and discards the whole buffer.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset the buffer is empty: `rob_empty`=1, `rob_full`=0, `alloc_ready`=1, `alloc_tag`=0 and no retirement or trap is signalled.
- R2: Each accepted allocation is given the tag shown on `alloc_tag` in that cycle. Tags advance by one per allocation and wrap modulo `DEPTH` (8).
- R3: After `DEPTH` allocations with no retirement, `rob_full`=1 and `alloc_ready`=0. An `alloc_valid` pulse while full is ignored, so the next tag stays unchanged.
- R4: A broadcast (`cdb_valid` with `cdb_tag`) marks its slot done and stores `cdb_value`. From the next cycle, a lookup of a register renamed to that tag returns `lk_ready`=1 and that value.
- R5: Allocating a slot of kind register-write (kind code 2'b00) points the rename map for `alloc_dest` at the new tag. A lookup of that register then reports `lk_busy`=1 and `lk_tag` equal to the tag. A register with no pending writer reports `lk_busy`=0.
- R6: Only the oldest slot retires, and only once it is done. A younger slot that completes early waits, so retirement order equals allocation order.
- R7: On retirement `cm_valid`=1 and `cm_tag`, `cm_pc` and `cm_value` describe the slot. `cm_reg_we`=1 with `cm_dest` only for kind 2'b00, and `cm_store_en`=1 only for kind 2'b01 (store).
- R8: Retiring a register-write slot clears the rename entry for its destination only if that entry still holds the retiring tag. A younger writer to the same register stays visible.
- R9: Retiring a branch (kind 2'b10) whose broadcast carried `cdb_mispred`=1 asserts `flush` with `cm_valid`. The next cycle the buffer is empty, all lookups report `lk_busy`=0, and the next tag is the branch tag plus one.
- R10: A done oldest slot whose broadcast carried `cdb_exc`=1 raises `trap` with `trap_pc` equal to its PC, asserts `flush`, and never asserts `cm_valid`. The next cycle the buffer is empty and the next tag equals the faulting tag.
- R11: In a cycle with `flush` asserted, `alloc_ready`=0 and an `alloc_valid` request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_kind | input | 2 | 00 register write, 01 store, 10 branch |
| alloc_dest | input | AW | Destination architectural register |
| alloc_pc | input | PCW | PC of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IW | Tag given to the allocation this cycle |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | IW | Slot the result belongs to |
| cdb_value | input | XLEN | Result value or store data |
| cdb_exc | input | 1 | The instruction faulted |
| cdb_mispred | input | 1 | The branch was mispredicted |
| lk_areg | input | RP*AW | Source registers to look up, one field per port |
| lk_busy | output | RP | Source has a pending writer |
| lk_tag | output | RP*IW | Tag of the pending writer |
| lk_ready | output | RP | Pending writer has finished |
| lk_value | output | RP*XLEN | Finished value of the pending writer |
| cm_valid | output | 1 | Oldest slot retires this cycle |
| cm_reg_we | output | 1 | Retirement writes a register |
| cm_store_en | output | 1 | Retirement performs a store |
| cm_dest | output | AW | Register written on retirement |
| cm_value | output | XLEN | Retired value or store data |
| cm_pc | output | PCW | PC of the retiring slot |
| cm_tag | output | IW | Tag of the retiring slot |
| flush | output | 1 | All in-flight state is discarded this cycle |
| trap | output | 1 | Oldest slot faulted |
| trap_pc | output | PCW | PC of the faulting slot |
| rob_full | output | 1 | No free slot |
| rob_empty | output | 1 | No occupied slot |

## Verification
The assertions assume that dispatch raises `alloc_valid` only while `alloc_ready` is high, and that a broadcast names only a slot that is occupied and not yet done, once per slot. The stimulus follows these rules. It tracks the expected tail in the bench, broadcasts each tag exactly once after its allocation, and makes only one deliberate request while full and one during a flush, both of which must be refused. `DEPTH` is assumed to be a power of two so that tag wrap equals pointer wrap.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_REG    = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_BRANCH = 2'b10
    } op_kind_e;

    typedef struct packed {
        logic     live;
        logic     done;
        logic     fault;
        logic     redirect;
        op_kind_e kind;
    } slot_flags_t;

    function automatic logic writes_reg(input op_kind_e k);
        return k == KIND_REG;
    endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          do_alloc,
    input  logic          do_retire,
    input  logic          do_flush,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic          full,
    output logic          empty
);
    logic [IW:0] count_q;
    logic [IW-1:0] head_adv;

    assign head_adv = head + IW'(do_retire);

    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            count_q <= '0;
        end else if (do_flush) begin
            head    <= head_adv;
            tail    <= head_adv;
            count_q <= '0;
        end else begin
            head    <= head_adv;
            tail    <= tail + IW'(do_alloc);
            count_q <= count_q + (IW+1)'(do_alloc) - (IW+1)'(do_retire);
        end
    end

    assign full  = (count_q == (IW+1)'(DEPTH));
    assign empty = (count_q == '0);
endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH),
    parameter int AW    = 4,
    parameter int XLEN  = 32,
    parameter int PCW   = 32,
    parameter int RP    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     alloc_en,
    input  logic [IW-1:0]            alloc_idx,
    input  op_kind_e                 alloc_kind,
    input  logic [AW-1:0]            alloc_dest,
    input  logic [PCW-1:0]           alloc_pc,
    input  logic                     cdb_valid,
    input  logic [IW-1:0]            cdb_tag,
    input  logic [XLEN-1:0]          cdb_value,
    input  logic                     cdb_exc,
    input  logic                     cdb_mispred,
    input  logic                     retire_en,
    input  logic [IW-1:0]            head_idx,
    output slot_flags_t              head_flags,
    output logic [AW-1:0]            head_dest,
    output logic [PCW-1:0]           head_pc,
    output logic [XLEN-1:0]          head_value,
    input  logic [RP-1:0][IW-1:0]    rd_tag,
    output logic [RP-1:0]            rd_done,
    output logic [RP-1:0][XLEN-1:0]  rd_value
);
    slot_flags_t     flags_q [DEPTH];
    logic [AW-1:0]   dest_q  [DEPTH];
    logic [PCW-1:0]  pc_q    [DEPTH];
    logic [XLEN-1:0] val_q   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                flags_q[i] <= '0;
            end else if (alloc_en && alloc_idx == IW'(i)) begin
                flags_q[i] <= '{live: 1'b1, done: 1'b0, fault: 1'b0,
                                redirect: 1'b0, kind: alloc_kind};
                dest_q[i]  <= alloc_dest;
                pc_q[i]    <= alloc_pc;
            end else begin
                if (retire_en && head_idx == IW'(i))
                    flags_q[i].live <= 1'b0;
                if (cdb_valid && cdb_tag == IW'(i) && flags_q[i].live) begin
                    flags_q[i].done     <= 1'b1;
                    flags_q[i].fault    <= cdb_exc;
                    flags_q[i].redirect <= cdb_mispred;
                    val_q[i]            <= cdb_value;
                end
            end
        end
    end

    assign head_flags = flags_q[head_idx];
    assign head_dest  = dest_q[head_idx];
    assign head_pc    = pc_q[head_idx];
    assign head_value = val_q[head_idx];

    for (genvar p = 0; p < RP; p++) begin : g_rd
        assign rd_done[p]  = flags_q[rd_tag[p]].live && flags_q[rd_tag[p]].done;
        assign rd_value[p] = val_q[rd_tag[p]];
    end
endmodule

// File: rtl/rob_rename_table.sv
module rob_rename_table #(
    parameter int AREGS = 16,
    parameter int AW    = $clog2(AREGS),
    parameter int IW    = 3,
    parameter int RP    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear_all,
    input  logic                   set_en,
    input  logic [AW-1:0]          set_reg,
    input  logic [IW-1:0]          set_tag,
    input  logic                   drop_en,
    input  logic [AW-1:0]          drop_reg,
    input  logic [IW-1:0]          drop_tag,
    input  logic [RP-1:0][AW-1:0]  q_reg,
    output logic [RP-1:0]          q_busy,
    output logic [RP-1:0][IW-1:0]  q_tag
);
    logic          pend_q  [AREGS];
    logic [IW-1:0] owner_q [AREGS];

    for (genvar r = 0; r < AREGS; r++) begin : g_map
        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                pend_q[r]  <= 1'b0;
                owner_q[r] <= '0;
            end else if (set_en && set_reg == AW'(r)) begin
                pend_q[r]  <= 1'b1;
                owner_q[r] <= set_tag;
            end else if (drop_en && drop_reg == AW'(r) && owner_q[r] == drop_tag) begin
                pend_q[r]  <= 1'b0;
            end
        end
    end

    for (genvar p = 0; p < RP; p++) begin : g_q
        assign q_busy[p] = pend_q[q_reg[p]];
        assign q_tag[p]  = owner_q[q_reg[p]];
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AREGS = 16,
    parameter int XLEN  = 32,
    parameter int PCW   = 32,
    parameter int RP    = 2,
    parameter int IW    = $clog2(DEPTH),
    parameter int AW    = $clog2(AREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [AW-1:0]     alloc_dest,
    input  logic [PCW-1:0]    alloc_pc,
    output logic              alloc_ready,
    output logic [IW-1:0]     alloc_tag,
    input  logic              cdb_valid,
    input  logic [IW-1:0]     cdb_tag,
    input  logic [XLEN-1:0]   cdb_value,
    input  logic              cdb_exc,
    input  logic              cdb_mispred,
    input  logic [RP*AW-1:0]  lk_areg,
    output logic [RP-1:0]     lk_busy,
    output logic [RP*IW-1:0]  lk_tag,
    output logic [RP-1:0]     lk_ready,
    output logic [RP*XLEN-1:0] lk_value,
    output logic              cm_valid,
    output logic              cm_reg_we,
    output logic              cm_store_en,
    output logic [AW-1:0]     cm_dest,
    output logic [XLEN-1:0]   cm_value,
    output logic [PCW-1:0]    cm_pc,
    output logic [IW-1:0]     cm_tag,
    output logic              flush,
    output logic              trap,
    output logic [PCW-1:0]    trap_pc,
    output logic              rob_full,
    output logic              rob_empty
);
    logic [IW-1:0]           head, tail;
    logic                    do_alloc, head_ready, retire;
    op_kind_e                kind_in;
    slot_flags_t             hflags;
    logic [AW-1:0]           hdest;
    logic [PCW-1:0]          hpc;
    logic [XLEN-1:0]         hval;
    logic [RP-1:0][AW-1:0]   q_reg;
    logic [RP-1:0][IW-1:0]   q_tag;
    logic [RP-1:0]           q_busy, q_done;
    logic [RP-1:0][XLEN-1:0] q_val;

    assign kind_in    = op_kind_e'(alloc_kind);
    assign head_ready = !rob_empty && hflags.live && hflags.done;
    assign trap       = head_ready && hflags.fault;
    assign retire     = head_ready && !hflags.fault;
    assign flush      = trap || (retire && hflags.kind == KIND_BRANCH && hflags.redirect);
    assign alloc_ready = !rob_full && !flush;
    assign do_alloc   = alloc_valid && alloc_ready;
    assign alloc_tag  = tail;

    rob_ptr_ctrl #(.DEPTH(DEPTH), .IW(IW)) u_ptr (
        .clk(clk), .rst(rst), .do_alloc(do_alloc), .do_retire(retire),
        .do_flush(flush), .head(head), .tail(tail),
        .full(rob_full), .empty(rob_empty)
    );

    rob_entry_array #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .XLEN(XLEN),
                      .PCW(PCW), .RP(RP)) u_slots (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_en(do_alloc), .alloc_idx(tail), .alloc_kind(kind_in),
        .alloc_dest(alloc_dest), .alloc_pc(alloc_pc),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .cdb_exc(cdb_exc), .cdb_mispred(cdb_mispred),
        .retire_en(retire), .head_idx(head),
        .head_flags(hflags), .head_dest(hdest), .head_pc(hpc), .head_value(hval),
        .rd_tag(q_tag), .rd_done(q_done), .rd_value(q_val)
    );

    rob_rename_table #(.AREGS(AREGS), .AW(AW), .IW(IW), .RP(RP)) u_map (
        .clk(clk), .rst(rst), .clear_all(flush),
        .set_en(do_alloc && writes_reg(kind_in)), .set_reg(alloc_dest), .set_tag(tail),
        .drop_en(retire && writes_reg(hflags.kind)), .drop_reg(hdest), .drop_tag(head),
        .q_reg(q_reg), .q_busy(q_busy), .q_tag(q_tag)
    );

    for (genvar p = 0; p < RP; p++) begin : g_port
        assign q_reg[p]                   = lk_areg[p*AW +: AW];
        assign lk_tag[p*IW +: IW]         = q_tag[p];
        assign lk_value[p*XLEN +: XLEN]   = q_val[p];
        assign lk_busy[p]                 = q_busy[p];
        assign lk_ready[p]                = q_busy[p] && q_done[p];
    end

    assign cm_valid    = retire;
    assign cm_reg_we   = retire && hflags.kind == KIND_REG;
    assign cm_store_en = retire && hflags.kind == KIND_STORE;
    assign cm_dest     = hdest;
    assign cm_value    = hval;
    assign cm_pc       = hpc;
    assign cm_tag      = head;
    assign trap_pc     = hpc;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic [IW-1:0] alloc_tag,
    input logic          cm_valid,
    input logic          trap,
    input logic          flush,
    input logic          rob_full,
    input logic          rob_empty
);
    localparam logic [IW-1:0] STEP = IW'(1);

    a_r1_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
        !(rob_full && rob_empty));

    a_r2_tag_advance: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> alloc_tag == $past(alloc_tag) + STEP);

    a_r3_full_refuses: assert property (@(posedge clk) disable iff (rst)
        rob_full |-> !alloc_ready);

    a_r6_no_retire_empty: assert property (@(posedge clk) disable iff (rst)
        rob_empty |-> !(cm_valid || trap));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> rob_empty);

    a_r10_trap_no_commit: assert property (@(posedge clk) disable iff (rst)
        trap |-> (flush && !cm_valid));

    a_r11_flush_refuses: assert property (@(posedge clk) disable iff (rst)
        flush |-> !alloc_ready);
endmodule

bind rob_core rob_core_chk #(.IW(IW)) u_rob_core_chk (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .cm_valid(cm_valid), .trap(trap), .flush(flush),
    .rob_full(rob_full), .rob_empty(rob_empty)
);

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, AREGS = 16, XLEN = 32, PCW = 32, RP = 2;
    localparam int IW = $clog2(DEPTH), AW = $clog2(AREGS);

    typedef struct {
        logic [1:0]      kind;
        logic [AW-1:0]   dest;
        logic [PCW-1:0]  pc;
        logic [XLEN-1:0] value;
        logic [IW-1:0]   tag;
        bit              exp_flush;
        bit              exp_trap;
    } exp_t;

    logic clk = 0, rst = 1;
    logic alloc_valid = 0; logic [1:0] alloc_kind = 0;
    logic [AW-1:0] alloc_dest = 0; logic [PCW-1:0] alloc_pc = 0;
    logic alloc_ready; logic [IW-1:0] alloc_tag;
    logic cdb_valid = 0; logic [IW-1:0] cdb_tag = 0; logic [XLEN-1:0] cdb_value = 0;
    logic cdb_exc = 0, cdb_mispred = 0;
    logic [RP*AW-1:0] lk_areg = 0;
    logic [RP-1:0] lk_busy, lk_ready; logic [RP*IW-1:0] lk_tag; logic [RP*XLEN-1:0] lk_value;
    logic cm_valid, cm_reg_we, cm_store_en; logic [AW-1:0] cm_dest;
    logic [XLEN-1:0] cm_value; logic [PCW-1:0] cm_pc; logic [IW-1:0] cm_tag;
    logic flush, trap; logic [PCW-1:0] trap_pc; logic rob_full, rob_empty;

    int checks = 0, errors = 0;
    exp_t q[$];
    logic [IW-1:0] exp_tail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .AREGS(AREGS), .XLEN(XLEN), .PCW(PCW), .RP(RP)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic alloc(input logic [1:0] k, input logic [AW-1:0] d, input logic [PCW-1:0] pc,
                         input logic [XLEN-1:0] v, input bit push, input bit fl, input bit tr);
        exp_t it;
        alloc_valid = 1; alloc_kind = k; alloc_dest = d; alloc_pc = pc;
        #1;
        chk(alloc_ready == 1'b1, "R2", "alloc_ready", alloc_ready, 1);
        chk(alloc_tag == exp_tail, "R2", "alloc_tag", alloc_tag, exp_tail);
        if (push) begin
            it.kind = k; it.dest = d; it.pc = pc; it.value = v; it.tag = exp_tail;
            it.exp_flush = fl; it.exp_trap = tr;
            q.push_back(it);
        end
        exp_tail = exp_tail + 1'b1;
        step();
        alloc_valid = 0;
    endtask

    task automatic bcast(input logic [IW-1:0] t, input logic [XLEN-1:0] v,
                         input logic e, input logic m);
        cdb_valid = 1; cdb_tag = t; cdb_value = v; cdb_exc = e; cdb_mispred = m;
        step();
        cdb_valid = 0; cdb_exc = 0; cdb_mispred = 0;
    endtask

    task automatic look(input logic [AW-1:0] r);
        lk_areg[AW-1:0] = r; lk_areg[2*AW-1:AW] = r + 1'b1;
        #1;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 40 && q.size() != 0; i++) step();
        step();
        chk(q.size() == 0, req, "pending retirements", q.size(), 0);
    endtask

    // Monitor: compares every retirement or trap with the scoreboard head
    always @(negedge clk) begin
        if (!rst && (cm_valid || trap)) begin
            if (q.size() == 0) begin
                chk(0, "R6", "unexpected retirement tag", cm_tag, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                if (it.exp_trap) begin
                    chk(trap && !cm_valid, "R10", "trap without commit", {trap, cm_valid}, 2'b10);
                    chk(trap_pc == it.pc, "R10", "trap_pc", trap_pc, it.pc);
                    chk(flush == 1'b1, "R10", "flush on trap", flush, 1);
                end else begin
                    chk(cm_valid && !trap, "R6", "commit valid", {cm_valid, trap}, 2'b10);
                    chk(cm_tag == it.tag, "R6", "retire order tag", cm_tag, it.tag);
                    chk(cm_pc == it.pc, "R7", "cm_pc", cm_pc, it.pc);
                    chk(cm_value == it.value, "R7", "cm_value", cm_value, it.value);
                    chk(cm_reg_we == (it.kind == 2'b00), "R7", "cm_reg_we", cm_reg_we, it.kind == 2'b00);
                    chk(cm_store_en == (it.kind == 2'b01), "R7", "cm_store_en", cm_store_en, it.kind == 2'b01);
                    if (it.kind == 2'b00) chk(cm_dest == it.dest, "R7", "cm_dest", cm_dest, it.dest);
                    chk(flush == it.exp_flush, "R9", "flush on retire", flush, it.exp_flush);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "R6", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        chk(rob_empty && !rob_full, "R1", "empty/full", {rob_empty, rob_full}, 2'b10);
        chk(alloc_ready == 1'b1, "R1", "alloc_ready", alloc_ready, 1);
        chk(alloc_tag == 0, "R1", "alloc_tag", alloc_tag, 0);
        chk(!cm_valid && !trap && !flush, "R1", "idle retire", {cm_valid, trap, flush}, 0);

        // R5 no pending writer, then rename
        look(3);
        chk(lk_busy[0] == 1'b0, "R5", "busy before rename", lk_busy[0], 0);
        alloc(2'b00, 3, 32'h100, 32'h33, 1, 0, 0);
        alloc(2'b00, 5, 32'h104, 32'h55, 1, 0, 0);
        alloc(2'b01, 0, 32'h108, 32'h77, 1, 0, 0);
        look(3);
        chk(lk_busy[0] && lk_tag[IW-1:0] == 0, "R5", "busy/tag r3", {lk_busy[0], lk_tag[IW-1:0]}, {1'b1, 3'd0});
        chk(lk_ready[0] == 1'b0, "R4", "not ready before result", lk_ready[0], 0);

        // R4/R6 younger completes first
        bcast(1, 32'h55, 0, 0);
        look(5);
        chk(lk_ready[0] && lk_value[XLEN-1:0] == 32'h55, "R4", "lookup value r5", lk_value[XLEN-1:0], 32'h55);
        chk(cm_valid == 1'b0, "R6", "younger must wait", cm_valid, 0);
        bcast(0, 32'h33, 0, 0);
        bcast(2, 32'h77, 0, 0);
        drain("R6");
        look(5);
        chk(lk_busy[0] == 1'b0, "R8", "r5 released after retire", lk_busy[0], 0);

        // R8 two writers to the same register
        alloc(2'b00, 7, 32'h120, 32'hA1, 1, 0, 0);
        alloc(2'b00, 7, 32'h124, 32'hA2, 1, 0, 0);
        bcast(3, 32'hA1, 0, 0);
        step(); step();
        look(7);
        chk(lk_busy[0] && lk_tag[IW-1:0] == 4, "R8", "younger owner kept", {lk_busy[0], lk_tag[IW-1:0]}, {1'b1, 3'd4});
        bcast(4, 32'hA2, 0, 0);
        drain("R8");
        look(7);
        chk(lk_busy[0] == 1'b0, "R8", "r7 released", lk_busy[0], 0);

        // R2/R3 fill with wrap, refuse when full
        for (int i = 0; i < DEPTH; i++) alloc(2'b00, 1, 32'h400 + i*4, 32'h1000 + i, 1, 0, 0);
        #1;
        chk(rob_full && !alloc_ready, "R3", "full refuses", {rob_full, alloc_ready}, 2'b10);
        alloc_valid = 1; alloc_kind = 0; alloc_dest = 9;
        step();
        alloc_valid = 0;
        look(9);
        chk(lk_busy[0] == 1'b0, "R3", "ignored alloc left no rename", lk_busy[0], 0);
        chk(alloc_tag == exp_tail, "R3", "tail unchanged when full", alloc_tag, exp_tail);
        for (int i = 0; i < DEPTH; i++) bcast(IW'(5 + i), 32'h1000 + i, 0, 0);
        drain("R2");
        chk(rob_empty && alloc_tag == exp_tail, "R2", "wrapped tail", alloc_tag, exp_tail);

        // R9/R11 mispredicted branch
        alloc(2'b10, 0, 32'h300, 32'hB0, 1, 1, 0);
        alloc(2'b00, 2, 32'h304, 32'hC0, 0, 0, 0);
        bcast(6, 32'hC0, 0, 0);
        bcast(5, 32'hB0, 0, 1);
        alloc_valid = 1; alloc_kind = 0; alloc_dest = 2;
        #1;
        chk(flush && !alloc_ready, "R11", "flush refuses alloc", {flush, alloc_ready}, 2'b10);
        step();
        alloc_valid = 0;
        look(2);
        chk(rob_empty == 1'b1, "R9", "empty after flush", rob_empty, 1);
        chk(lk_busy[0] == 1'b0, "R9", "rename wiped", lk_busy[0], 0);
        exp_tail = 3'd6;
        chk(alloc_tag == exp_tail, "R9", "tag after flush", alloc_tag, exp_tail);

        // R10 faulting head
        alloc(2'b00, 4, 32'h200, 32'hD0, 1, 0, 1);
        alloc(2'b00, 5, 32'h204, 32'hD1, 0, 0, 0);
        bcast(6, 32'hD0, 1, 0);
        chk(trap && !cm_valid, "R10", "trap raised", {trap, cm_valid}, 2'b10);
        step();
        exp_tail = 3'd6;
        chk(rob_empty && alloc_tag == exp_tail, "R10", "empty, tag back", alloc_tag, exp_tail);
        look(4);
        chk(lk_busy[0] == 1'b0, "R10", "rename wiped", lk_busy[0], 0);
        chk(q.size() == 0, "R6", "scoreboard empty", q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule